// File: doc/BRIEF.md
# Configurable Logic Slice

This block is a soft model of one slice of a programmable logic fabric. Two 4-input lookup tables each take 16 configuration bits and 4 data inputs. A mux steered by a select input joins the two table outputs into one 5-input function. Each table position also has a carry cell. Carry enters from the neighbouring slice, passes through position 0 and then position 1, and leaves toward the next slice. Each position feeds its own storage element. All configuration arrives on static input ports, held steady while the slice runs.

Each storage element is set up on its own. It works either as an edge-triggered flip-flop or as a level-sensitive latch, and this choice is a two-value mode (flop, latch). A polarity bit picks the active condition. A flop captures on the rising edge (bit 0) or on the falling edge (bit 1). A latch is open while the clock is high (bit 0) or low (bit 1), so each latch alternates between an open phase and a closed phase. A shared clock-enable gates capture and transparency. A shared set/reset input loads a per-register value, either synchronously (at the active edge or during the open phase) or asynchronously (at once). Set/reset wins over the clock-enable. The data input of each register comes from its position's function output or from a bypass input.

The state of the block is simple. Each storage element holds one bit. Its mode selects whether that bit comes from the flop path or the latch path. Within latch mode, the clock level moves the element between the open and closed phases.

Top module: `slice_cell`

## Requirements
- R1: With arithmetic off, `fn_out0` equals `lut0_init[lut0_in]` and `fn_out1` equals `lut1_init[lut1_in]`. Bit 0 of each input vector is the least significant address bit.
- R2: `wide_out` equals the table-1 output when `mux_sel` is 1 and the table-0 output when it is 0.
- R3: Each position `i` has a carry cell. If table `i` outputs 1, its carry-out equals its carry-in. Otherwise its carry-out equals bit 0 of that position's input vector. `carry_in` feeds position 0, position 0 feeds position 1, and position 1 drives `carry_out`. When `arith_en` is 1, each function output becomes (table output XOR that position's carry-in).
- R4: When `reg_d_byp[i]` is 1, register `i` takes its data from its bypass input (`mux_sel` for register 0, `aux_in` for register 1). When the bit is 0, the data comes from that position's function output.
- R5: In flop mode (`reg_latch[i]`=0), a register captures its data on the rising clock edge when `reg_clk_inv[i]`=0, or on the falling edge when it is 1, and only if `clk_en` is 1. It holds its value when `clk_en` is 0 and does not follow data changes between edges.
- R6: In latch mode (`reg_latch[i]`=1), a register with `clk_en`=1 follows its data while the clock is high (`reg_clk_inv[i]`=0) or low (`reg_clk_inv[i]`=1). It holds its value during the opposite level.
- R7: When `reg_sr_async[i]`=0, `set_rst` loads the set/reset value at the next active edge (flop) or during the open phase (latch), whatever the value of `clk_en`. A flop register does not change before that edge.
- R8: When `reg_sr_async[i]`=1, `set_rst` forces the register to its set/reset value at once, with no clock edge needed, and keeps it there while `set_rst` stays high.
- R9: `reg_sr_val[i]` selects whether set/reset drives register `i` to 1 or to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| clk_en | input | 1 | Shared clock-enable |
| set_rst | input | 1 | Shared local set/reset |
| mux_sel | input | 1 | Expansion select and bypass data for register 0 |
| aux_in | input | 1 | Bypass data for register 1 |
| lut0_in | input | 4 | Table 0 data inputs |
| lut1_in | input | 4 | Table 1 data inputs |
| carry_in | input | 1 | Carry from the previous slice |
| lut0_init | input | 16 | Table 0 contents |
| lut1_init | input | 16 | Table 1 contents |
| arith_en | input | 1 | Function outputs carry sums |
| reg_latch | input | 2 | Per-register latch mode |
| reg_clk_inv | input | 2 | Per-register clock polarity |
| reg_sr_async | input | 2 | Per-register asynchronous set/reset |
| reg_sr_val | input | 2 | Per-register set/reset value |
| reg_d_byp | input | 2 | Per-register bypass data select |
| fn_out0 | output | 1 | Position 0 function output |
| fn_out1 | output | 1 | Position 1 function output |
| wide_out | output | 1 | 5-input function output |
| reg_q0 | output | 1 | Register 0 output |
| reg_q1 | output | 1 | Register 1 output |
| carry_out | output | 1 | Carry to the next slice |

## Verification
A corrupted storage bit shows on `reg_q0` or `reg_q1` at the next check point. In flop mode that is one clock period later. In latch mode it is within the same open phase, because the latch drives its port directly. A register stuck in the wrong mode or polarity behaves differently when data toggles between edges or during the closed phase. Probes half a cycle apart expose such a fault before the next active edge. Carry or table faults are purely combinational, so they appear on the function, wide and carry outputs as soon as the inputs settle.

// File: rtl/slice_pkg.sv
`timescale 1ns/100ps
package slice_pkg;
    localparam int LUT_K = 4;
    localparam int LUT_W = 1 << LUT_K;
    localparam int NPOS  = 2;

    typedef enum logic {
        ST_FLOP  = 1'b0,
        ST_LATCH = 1'b1
    } store_mode_e;

    typedef enum logic {
        FO_LOGIC = 1'b0,
        FO_ARITH = 1'b1
    } fout_sel_e;
endpackage

// File: rtl/slice_lut.sv
`timescale 1ns/100ps
module slice_lut #(
    parameter int K = 4,
    localparam int W = 1 << K
) (
    input  logic [W-1:0] init,
    input  logic [K-1:0] addr,
    output logic         y
);
    // Binary mux tree: level l halves the candidate set using address bit l.
    logic [2*W-2:0] node;

    assign node[W-1:0] = init;

    for (genvar lv = 0; lv < K; lv++) begin : g_level
        localparam int IN_BASE  = 2*W - (2*W >> lv);
        localparam int OUT_BASE = 2*W - (W >> lv);
        localparam int OUT_N    = W >> (lv + 1);
        for (genvar n = 0; n < OUT_N; n++) begin : g_node
            assign node[OUT_BASE + n] = addr[lv] ? node[IN_BASE + 2*n + 1]
                                                 : node[IN_BASE + 2*n];
        end
    end

    assign y = node[2*W-2];
endmodule

// File: rtl/slice_carry.sv
`timescale 1ns/100ps
module slice_carry (
    input  logic prop,
    input  logic gen,
    input  logic cin,
    output logic sum,
    output logic cout
);
    assign cout = prop ? cin : gen;
    assign sum  = prop ^ cin;
endmodule

// File: rtl/slice_store.sv
`timescale 1ns/100ps
module slice_store
    import slice_pkg::*;
(
    input  logic        clk,
    input  logic        ce,
    input  logic        sr,
    input  logic        d,
    input  store_mode_e mode,
    input  logic        clk_inv,
    input  logic        sr_async,
    input  logic        sr_val,
    output logic        q
);
    logic clk_act;
    logic sr_now;
    logic sr_clk;
    logic flop_q;
    logic latch_q;

    assign clk_act = clk ^ clk_inv;
    assign sr_now  = sr & sr_async;
    assign sr_clk  = sr & ~sr_async;

    // Edge path: active edge chosen by the polarity bit.
    always_ff @(posedge clk_act or posedge sr_now) begin
        if (sr_now) begin
            flop_q <= sr_val;
        end else if (sr_clk) begin
            flop_q <= sr_val;
        end else if (ce) begin
            flop_q <= d;
        end
    end

    // Level path: open while the selected level is present.
    always_latch begin
        if (sr_now) begin
            latch_q <= sr_val;
        end else if (clk_act) begin
            if (sr_clk) begin
                latch_q <= sr_val;
            end else if (ce) begin
                latch_q <= d;
            end
        end
    end

    always_comb begin
        unique case (mode)
            ST_FLOP:  q = flop_q;
            ST_LATCH: q = latch_q;
        endcase
    end
endmodule

// File: rtl/slice_cell.sv
`timescale 1ns/100ps
module slice_cell
    import slice_pkg::*;
(
    input  logic              clk,
    input  logic              clk_en,
    input  logic              set_rst,
    input  logic              mux_sel,
    input  logic              aux_in,
    input  logic [LUT_K-1:0]  lut0_in,
    input  logic [LUT_K-1:0]  lut1_in,
    input  logic              carry_in,
    input  logic [LUT_W-1:0]  lut0_init,
    input  logic [LUT_W-1:0]  lut1_init,
    input  logic              arith_en,
    input  logic [NPOS-1:0]   reg_latch,
    input  logic [NPOS-1:0]   reg_clk_inv,
    input  logic [NPOS-1:0]   reg_sr_async,
    input  logic [NPOS-1:0]   reg_sr_val,
    input  logic [NPOS-1:0]   reg_d_byp,
    output logic              fn_out0,
    output logic              fn_out1,
    output logic              wide_out,
    output logic              reg_q0,
    output logic              reg_q1,
    output logic              carry_out
);
    logic [NPOS-1:0][LUT_K-1:0] addr;
    logic [NPOS-1:0][LUT_W-1:0] init;
    logic [NPOS:0]              carry;
    logic [NPOS-1:0]            lut_out;
    logic [NPOS-1:0]            sum_out;
    logic [NPOS-1:0]            f_out;
    logic [NPOS-1:0]            byp;
    logic [NPOS-1:0]            d_sel;
    logic [NPOS-1:0]            q_out;
    fout_sel_e                  fsel;

    assign addr[0]  = lut0_in;
    assign addr[1]  = lut1_in;
    assign init[0]  = lut0_init;
    assign init[1]  = lut1_init;
    assign byp      = {aux_in, mux_sel};
    assign carry[0] = carry_in;
    assign fsel     = fout_sel_e'(arith_en);

    for (genvar i = 0; i < NPOS; i++) begin : g_pos
        logic f_bit;

        slice_lut #(.K(LUT_K)) u_lut (
            .init (init[i]),
            .addr (addr[i]),
            .y    (lut_out[i])
        );

        slice_carry u_carry (
            .prop (lut_out[i]),
            .gen  (addr[i][0]),
            .cin  (carry[i]),
            .sum  (sum_out[i]),
            .cout (carry[i+1])
        );

        always_comb begin
            unique case (fsel)
                FO_LOGIC: f_bit = lut_out[i];
                FO_ARITH: f_bit = sum_out[i];
            endcase
        end

        assign f_out[i] = f_bit;
        assign d_sel[i] = reg_d_byp[i] ? byp[i] : f_out[i];

        slice_store u_store (
            .clk      (clk),
            .ce       (clk_en),
            .sr       (set_rst),
            .d        (d_sel[i]),
            .mode     (store_mode_e'(reg_latch[i])),
            .clk_inv  (reg_clk_inv[i]),
            .sr_async (reg_sr_async[i]),
            .sr_val   (reg_sr_val[i]),
            .q        (q_out[i])
        );
    end

    assign wide_out  = mux_sel ? lut_out[1] : lut_out[0];
    assign fn_out0   = f_out[0];
    assign fn_out1   = f_out[1];
    assign reg_q0    = q_out[0];
    assign reg_q1    = q_out[1];
    assign carry_out = carry[NPOS];
endmodule

// File: rtl/slice_cell_chk.sv
`timescale 1ns/100ps
module slice_cell_chk
    import slice_pkg::*;
(
    input logic            clk,
    input logic            set_rst,
    input logic            clk_en,
    input logic            carry_in,
    input logic            carry_out,
    input logic [NPOS-1:0] lut_out,
    input logic [NPOS-1:0] d_sel,
    input logic [NPOS-1:0] reg_q,
    input logic [NPOS-1:0] reg_latch,
    input logic [NPOS-1:0] reg_clk_inv,
    input logic [NPOS-1:0] reg_sr_async,
    input logic [NPOS-1:0] reg_sr_val
);
    logic armed;
    initial armed = 1'b0;
    always @(posedge clk) begin
        if (set_rst) armed <= 1'b1;
    end

    // R3
    carry_pass_chk: assert property (@(posedge clk) disable iff (!armed)
        (&lut_out) |-> (carry_out == carry_in));

    for (genvar i = 0; i < NPOS; i++) begin : g_reg
        // R5
        capture_chk: assert property (@(posedge clk) disable iff (!armed)
            (!set_rst && clk_en && !reg_latch[i] && !reg_clk_inv[i])
            |=> (set_rst || reg_q[i] == $past(d_sel[i])));

        // R5
        hold_chk: assert property (@(posedge clk) disable iff (!armed)
            (!set_rst && !clk_en && !reg_latch[i] && !reg_clk_inv[i])
            |=> (set_rst || $stable(reg_q[i])));

        // R7
        sync_load_chk: assert property (@(posedge clk) disable iff (!armed)
            (set_rst && !reg_sr_async[i] && !reg_latch[i] && !reg_clk_inv[i])
            |=> (reg_q[i] == reg_sr_val[i]));

        // R8
        async_force_chk: assert property (@(posedge clk) disable iff (!armed)
            (set_rst && reg_sr_async[i]) |-> (reg_q[i] == reg_sr_val[i]));
    end
endmodule

bind slice_cell slice_cell_chk chk_i (
    .clk          (clk),
    .set_rst      (set_rst),
    .clk_en       (clk_en),
    .carry_in     (carry_in),
    .carry_out    (carry_out),
    .lut_out      (lut_out),
    .d_sel        (d_sel),
    .reg_q        (q_out),
    .reg_latch    (reg_latch),
    .reg_clk_inv  (reg_clk_inv),
    .reg_sr_async (reg_sr_async),
    .reg_sr_val   (reg_sr_val)
);

// File: tb/slice_cell_tb_top.sv
`timescale 1ns/100ps
module slice_cell_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        clk_en = 1'b0, set_rst = 1'b0, mux_sel = 1'b0, aux_in = 1'b0;
    logic        carry_in = 1'b0, arith_en = 1'b0;
    logic [3:0]  lut0_in = '0, lut1_in = '0;
    logic [15:0] lut0_init = '0, lut1_init = '0;
    logic [1:0]  reg_latch = '0, reg_clk_inv = '0, reg_sr_async = '0;
    logic [1:0]  reg_sr_val = '0, reg_d_byp = '0;
    logic        fn_out0, fn_out1, wide_out, reg_q0, reg_q1, carry_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] qm;

    slice_cell dut_i (
        .clk(clk), .clk_en(clk_en), .set_rst(set_rst), .mux_sel(mux_sel),
        .aux_in(aux_in), .lut0_in(lut0_in), .lut1_in(lut1_in),
        .carry_in(carry_in), .lut0_init(lut0_init), .lut1_init(lut1_init),
        .arith_en(arith_en), .reg_latch(reg_latch), .reg_clk_inv(reg_clk_inv),
        .reg_sr_async(reg_sr_async), .reg_sr_val(reg_sr_val),
        .reg_d_byp(reg_d_byp), .fn_out0(fn_out0), .fn_out1(fn_out1),
        .wide_out(wide_out), .reg_q0(reg_q0), .reg_q1(reg_q1),
        .carry_out(carry_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // {f0, f1, wide, carry_out}
    function automatic logic [3:0] comb_exp();
        logic l0, l1, k1, fa, fb;
        l0 = lut0_init[lut0_in];
        l1 = lut1_init[lut1_in];
        k1 = l0 ? carry_in : lut0_in[0];
        fa = arith_en ? (l0 ^ carry_in) : l0;
        fb = arith_en ? (l1 ^ k1) : l1;
        return {fa, fb, (mux_sel ? l1 : l0), (l1 ? k1 : lut1_in[0])};
    endfunction

    task automatic comb_sweep();
        logic [3:0] e;
        logic [3:0] r;
        r = 4'($urandom_range(15));
        for (int ad = 0; ad < 16; ad++) begin
            for (int v = 0; v < 4; v++) begin
                lut0_in  = 4'(ad);
                lut1_in  = 4'(ad) ^ r;
                mux_sel  = v[0];
                carry_in = v[1];
                #1;
                e = comb_exp();
                check(arith_en ? "R3 sum0" : "R1 table0", fn_out0, e[3]);
                check(arith_en ? "R3 sum1" : "R1 table1", fn_out1, e[2]);
                check("R2 wide", wide_out, e[1]);
                check("R3 carry_out", carry_out, e[0]);
            end
        end
    endtask

    task automatic run_cfg(input logic lat, input logic inv, input logic asy);
        logic [3:0] e;
        logic [1:0] dn;
        string lbl;
        @(posedge clk); #1;
        reg_latch    = {lat, lat};
        reg_clk_inv  = {inv, inv};
        reg_sr_async = {asy, asy};
        reg_sr_val   = 2'($urandom);
        reg_d_byp    = 2'($urandom);
        clk_en       = 1'($urandom);
        set_rst      = 1'b1;
        if (asy) begin
            #0.5;
            check("R8 immediate q0", reg_q0, reg_sr_val[0]);
            check("R8 immediate q1", reg_q1, reg_sr_val[1]);
        end
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R9 value q0", reg_q0, reg_sr_val[0]);
        check("R9 value q1", reg_q1, reg_sr_val[1]);
        qm = reg_sr_val;
        set_rst = 1'b0;

        // random steps, one active edge or open phase each
        for (int s = 0; s < 12; s++) begin
            clk_en   = 1'($urandom);
            mux_sel  = 1'($urandom);
            aux_in   = 1'($urandom);
            lut0_in  = 4'($urandom);
            lut1_in  = 4'($urandom);
            carry_in = 1'($urandom);
            set_rst  = ($urandom_range(7) == 0);
            e  = comb_exp();
            dn[0] = reg_d_byp[0] ? mux_sel : e[3];
            dn[1] = reg_d_byp[1] ? aux_in : e[2];
            for (int i = 0; i < 2; i++) begin
                qm[i] = set_rst ? reg_sr_val[i] : (clk_en ? dn[i] : qm[i]);
            end
            lbl = set_rst ? (asy ? "R8 step" : "R7 step") : (lat ? "R6 step" : "R5 step");
            @(posedge clk); #1;
            check({lbl, reg_d_byp[0] ? " R4 bypass q0" : " R4 table q0"}, reg_q0, qm[0]);
            check({lbl, reg_d_byp[1] ? " R4 bypass q1" : " R4 table q1"}, reg_q1, qm[1]);
        end
        set_rst = 1'b0;

        // directed: transparency versus edge, then closed phase
        reg_d_byp = 2'b11;
        clk_en    = 1'b0;
        if (inv) #2;
        clk_en  = 1'b1;
        mux_sel = ~qm[0];
        aux_in  = ~qm[1];
        #0.5;
        check(lat ? "R6 open follows q0" : "R5 no edge q0", reg_q0, lat ? ~qm[0] : qm[0]);
        check(lat ? "R6 open follows q1" : "R5 no edge q1", reg_q1, lat ? ~qm[1] : qm[1]);
        if (lat) qm = ~qm;
        #1;
        mux_sel = ~mux_sel;
        aux_in  = ~aux_in;
        #0.5;
        check(lat ? "R6 closed hold q0" : "R5 between edges q0", reg_q0, qm[0]);
        check(lat ? "R6 closed hold q1" : "R5 between edges q1", reg_q1, qm[1]);
        @(posedge clk); #1;
        qm = {aux_in, mux_sel};
        check("R5 R6 resume q0", reg_q0, qm[0]);
        check("R5 R6 resume q1", reg_q1, qm[1]);

        // set/reset timing, overriding the enable
        clk_en  = 1'b1;
        set_rst = 1'b1;
        if (!lat && !asy) begin
            #0.5;
            check("R7 waits for edge q0", reg_q0, qm[0]);
            check("R7 waits for edge q1", reg_q1, qm[1]);
        end else if (asy) begin
            #0.5;
            check("R8 no clock needed q0", reg_q0, reg_sr_val[0]);
            check("R8 no clock needed q1", reg_q1, reg_sr_val[1]);
        end
        @(posedge clk); #1;
        check(asy ? "R8 held q0" : "R7 loaded q0", reg_q0, reg_sr_val[0]);
        check(asy ? "R8 held q1" : "R7 loaded q1", reg_q1, reg_sr_val[1]);
        qm = reg_sr_val;
        set_rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // reset state
        reg_sr_async = 2'b11;
        reg_sr_val   = 2'b00;
        set_rst      = 1'b1;
        #1;
        check("R8 reset q0", reg_q0, 1'b0);
        check("R8 reset q1", reg_q1, 1'b0);
        @(posedge clk); #1;
        set_rst = 1'b0;

        // directed tables: all-ones propagates carry, all-zeros generates from bit 0
        lut0_init = 16'hFFFF; lut1_init = 16'hFFFF; arith_en = 1'b1;
        comb_sweep();
        lut0_init = 16'h0000; lut1_init = 16'hAAAA; arith_en = 1'b1;
        comb_sweep();
        for (int k = 0; k < 6; k++) begin
            lut0_init = 16'($urandom);
            lut1_init = 16'($urandom);
            arith_en  = k[0];
            comb_sweep();
        end

        for (int rep = 0; rep < 3; rep++) begin
            lut0_init = 16'($urandom);
            lut1_init = 16'($urandom);
            arith_en  = 1'($urandom);
            for (int c = 0; c < 8; c++) begin
                run_cfg(c[0], c[1], c[2]);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule